// File: doc/BRIEF.md
# Descriptor-Chained DMA Fetcher

This block is the control side of a DMA channel. Software places buffer descriptors in memory, writes the address of the first one, and pulses start. The engine then walks the descriptors over a 16-bit memory master port. For each one it hands the buffer address and length to a separate transfer engine and waits for that engine to report completion. It then writes the completion status back into the descriptor and moves on. The data transfer itself happens elsewhere.

Two descriptor layouts are supported, and the layout is chosen at each start. In table layout, descriptors sit back to back in memory. In chained layout, each descriptor carries a pointer to the next one, so software can splice buffers in and out of the chain.

A length of zero ends the walk and raises an end interrupt. An optional recycle setting clears every length field just after the engine reads it. This lets a chain that wraps onto itself stop at a buffer that software has not yet refilled with a nonzero length.

Every descriptor field is one 16-bit word at a fixed byte offset from the descriptor base:

| Offset | Field |
|---|---|
| +0 | Buffer address, low half |
| +2 | Buffer address, high half |
| +4 | Length |
| +6 | Status |
| +8 | Next pointer, low half (chained layout only) |
| +10 | Next pointer, high half (chained layout only) |

Top module: `dsc_fetch`

## Requirements
- R1: After reset, `busy`, `mem_req`, `desc_valid`, `irq_end` and `irq_done` are all low, and the engine stays idle until `start` is pulsed.
- R2: In table layout (`start_list`=0), the engine reads the buffer address low half at descriptor base +0, the high half at +2 and the length at +4. The next descriptor begins at base +8.
- R3: In chained layout (`start_list`=1), the engine reads the next pointer after a nonzero length: low half at +8, high half at +10. The next descriptor begins at the address held in that pointer.
- R4: When a length of zero is read, the engine issues no descriptor. It returns to idle, with `busy` low, and pulses `irq_end` high for exactly one cycle, in the first idle cycle.
- R5: With `start_ring`=1, every length read is followed at once by a write of 0x0000 to the same +4 address. This write comes before the descriptor is issued or the walk stops. With `start_ring`=0, the length field is never written.
- R6: For each nonzero length, `desc_valid` rises with `desc_addr` (high half first read from +2, low half from +0) and `desc_len`. These stay stable until `xfer_done` is sampled high.
- R7: The `xfer_status` value sampled together with `xfer_done` is written to the descriptor's +6 address. When that write is acknowledged, `irq_done` pulses and the next descriptor is fetched.
- R8: A `start` pulse while `busy` is high is ignored: the walk in progress continues unchanged.
- R9: A memory request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a walk when idle |
| start_list | input | 1 | Layout for this walk: 1 chained, 0 table |
| start_ring | input | 1 | Clear each length field after reading it |
| head_ptr | input | AW | Byte address of the first descriptor |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address of the 16-bit word |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| desc_valid | output | 1 | Descriptor offered to the transfer engine |
| desc_addr | output | AW | Buffer start address |
| desc_len | output | DW | Buffer length, never zero |
| xfer_done | input | 1 | Transfer engine finished the buffer |
| xfer_status | input | DW | Completion status to store |
| irq_end | output | 1 | One-cycle pulse: zero length ended the walk |
| irq_done | output | 1 | One-cycle pulse: a buffer status was written back |

## Verification
Issuing a descriptor and accepting its completion can fall in the same clock cycle. This happens when the transfer engine already holds `xfer_done` high at the moment `desc_valid` rises. The bench provokes this by holding `xfer_done` high through a whole chained, recycling walk. It then judges the result from memory and counters: each status word must appear at the right +6 address with the value for its own length, and the number of descriptors offered must equal the number of `irq_done` pulses.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_A0,
      ST_RD_A1,
      ST_RD_LEN,
      ST_WR_LEN,
      ST_RD_N0,
      ST_RD_N1,
      ST_ISSUE,
      ST_WR_STAT
   } dsc_state_e;

   localparam int unsigned OFS_ALO  = 0;
   localparam int unsigned OFS_AHI  = 2;
   localparam int unsigned OFS_LEN  = 4;
   localparam int unsigned OFS_STAT = 6;
   localparam int unsigned OFS_NLO  = 8;
   localparam int unsigned OFS_NHI  = 10;

   localparam int unsigned TABLE_ENTRY_BYTES = 8;

   // byte offset inside the descriptor touched by each access state
   function automatic logic [3:0] field_ofs(dsc_state_e s);
      case (s)
         ST_RD_A1:   field_ofs = 4'(OFS_AHI);
         ST_RD_LEN,
         ST_WR_LEN:  field_ofs = 4'(OFS_LEN);
         ST_WR_STAT: field_ofs = 4'(OFS_STAT);
         ST_RD_N0:   field_ofs = 4'(OFS_NLO);
         ST_RD_N1:   field_ofs = 4'(OFS_NHI);
         default:    field_ofs = 4'(OFS_ALO);
      endcase
   endfunction

endpackage

// File: rtl/dsc_cursor.sv
module dsc_cursor #(
   parameter int unsigned AW      = 32,
   parameter int unsigned DW      = 16,
   parameter bit          LIST_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_head,
   input  logic [AW-1:0] head,
   input  logic          ld_nlo,
   input  logic          ld_nhi,
   input  logic [DW-1:0] rdata,
   input  logic          adv,
   input  logic          list_mode,
   input  logic [3:0]    ofs,
   output logic [AW-1:0] field_addr
);
   import dsc_pkg::*;

   logic [AW-1:0] ent_q;
   logic [AW-1:0] next_ent;

   if (LIST_EN) begin : g_list
      logic [AW-1:0] ptr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_q <= '0;
         end else begin
            if (ld_nlo) ptr_q[DW-1:0]  <= rdata;
            if (ld_nhi) ptr_q[AW-1:DW] <= rdata;
         end
      end
      assign next_ent = list_mode ? ptr_q : ent_q + AW'(TABLE_ENTRY_BYTES);
   end else begin : g_table
      logic unused_in;
      assign unused_in = ^{ld_nlo, ld_nhi, rdata, list_mode};
      assign next_ent  = ent_q + AW'(TABLE_ENTRY_BYTES);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ent_q <= '0;
      else if (ld_head) ent_q <= head;
      else if (adv)     ent_q <= next_ent;
   end

   assign field_addr = ent_q + AW'(ofs);

endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl #(
   parameter int unsigned AW      = 32,
   parameter int unsigned DW      = 16,
   parameter bit          LIST_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_list,
   input  logic          start_ring,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   input  logic          xfer_done,
   input  logic [DW-1:0] xfer_status,
   output logic          mem_req,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   output logic [3:0]    ofs,
   output logic          ld_head,
   output logic          ld_nlo,
   output logic          ld_nhi,
   output logic          adv,
   output logic          list_mode,
   output logic          busy,
   output logic          desc_valid,
   output logic [AW-1:0] desc_addr,
   output logic [DW-1:0] desc_len,
   output logic          irq_end,
   output logic          irq_done
);
   import dsc_pkg::*;

   dsc_state_e    state_q, state_d, after_len;
   logic          list_q, ring_q, stop;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] len_q, stat_q;
   logic          irq_end_q, irq_done_q;

   assign list_mode = LIST_EN ? list_q : 1'b0;
   assign after_len = list_mode ? ST_RD_N0 : ST_ISSUE;

   always_comb begin
      state_d = state_q;
      stop    = 1'b0;
      case (state_q)
         ST_IDLE:   if (start)   state_d = ST_RD_A0;
         ST_RD_A0:  if (mem_ack) state_d = ST_RD_A1;
         ST_RD_A1:  if (mem_ack) state_d = ST_RD_LEN;
         ST_RD_LEN: if (mem_ack) begin
            if (ring_q)                state_d = ST_WR_LEN;
            else if (mem_rdata == '0) begin
               stop    = 1'b1;
               state_d = ST_IDLE;
            end else                   state_d = after_len;
         end
         ST_WR_LEN: if (mem_ack) begin
            if (len_q == '0) begin
               stop    = 1'b1;
               state_d = ST_IDLE;
            end else state_d = after_len;
         end
         ST_RD_N0:   if (mem_ack)   state_d = ST_RD_N1;
         ST_RD_N1:   if (mem_ack)   state_d = ST_ISSUE;
         ST_ISSUE:   if (xfer_done) state_d = ST_WR_STAT;
         ST_WR_STAT: if (mem_ack)   state_d = ST_RD_A0;
         default:                   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         list_q     <= 1'b0;
         ring_q     <= 1'b0;
         addr_q     <= '0;
         len_q      <= '0;
         stat_q     <= '0;
         irq_end_q  <= 1'b0;
         irq_done_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         irq_end_q  <= stop;
         irq_done_q <= (state_q == ST_WR_STAT) && mem_ack;
         if (ld_head) begin
            list_q <= start_list;
            ring_q <= start_ring;
         end
         if (state_q == ST_RD_A0 && mem_ack)  addr_q[DW-1:0]  <= mem_rdata;
         if (state_q == ST_RD_A1 && mem_ack)  addr_q[AW-1:DW] <= mem_rdata;
         if (state_q == ST_RD_LEN && mem_ack) len_q           <= mem_rdata;
         if (state_q == ST_ISSUE && xfer_done) stat_q         <= xfer_status;
      end
   end

   always_comb begin
      case (state_q)
         ST_RD_A0, ST_RD_A1, ST_RD_LEN, ST_WR_LEN,
         ST_RD_N0, ST_RD_N1, ST_WR_STAT: mem_req = 1'b1;
         default:                        mem_req = 1'b0;
      endcase
   end

   assign mem_we     = (state_q == ST_WR_LEN) || (state_q == ST_WR_STAT);
   assign mem_wdata  = (state_q == ST_WR_STAT) ? stat_q : '0;
   assign ofs        = field_ofs(state_q);
   assign ld_head    = (state_q == ST_IDLE) && start;
   assign ld_nlo     = (state_q == ST_RD_N0) && mem_ack;
   assign ld_nhi     = (state_q == ST_RD_N1) && mem_ack;
   assign adv        = (state_q == ST_WR_STAT) && mem_ack;
   assign busy       = (state_q != ST_IDLE);
   assign desc_valid = (state_q == ST_ISSUE);
   assign desc_addr  = addr_q;
   assign desc_len   = len_q;
   assign irq_end    = irq_end_q;
   assign irq_done   = irq_done_q;

endmodule

// File: rtl/dsc_fetch.sv
module dsc_fetch #(
   parameter int unsigned AW      = 32,
   parameter int unsigned DW      = 16,
   parameter bit          LIST_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_list,
   input  logic          start_ring,
   input  logic [AW-1:0] head_ptr,
   output logic          busy,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ack,
   output logic          desc_valid,
   output logic [AW-1:0] desc_addr,
   output logic [DW-1:0] desc_len,
   input  logic          xfer_done,
   input  logic [DW-1:0] xfer_status,
   output logic          irq_end,
   output logic          irq_done
);

   if (AW != 2 * DW) begin : g_bad_width
      $error("dsc_fetch: AW must be twice DW");
   end
   if (DW < 8) begin : g_bad_dw
      $error("dsc_fetch: DW below 8 bits");
   end

   logic [3:0] ofs;
   logic       ld_head, ld_nlo, ld_nhi, adv, list_mode;

   dsc_ctrl #(.AW(AW), .DW(DW), .LIST_EN(LIST_EN)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_list (start_list),
      .start_ring (start_ring),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .xfer_done  (xfer_done),
      .xfer_status(xfer_status),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_wdata  (mem_wdata),
      .ofs        (ofs),
      .ld_head    (ld_head),
      .ld_nlo     (ld_nlo),
      .ld_nhi     (ld_nhi),
      .adv        (adv),
      .list_mode  (list_mode),
      .busy       (busy),
      .desc_valid (desc_valid),
      .desc_addr  (desc_addr),
      .desc_len   (desc_len),
      .irq_end    (irq_end),
      .irq_done   (irq_done)
   );

   dsc_cursor #(.AW(AW), .DW(DW), .LIST_EN(LIST_EN)) u_cursor (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_head   (ld_head),
      .head      (head_ptr),
      .ld_nlo    (ld_nlo),
      .ld_nhi    (ld_nhi),
      .rdata     (mem_rdata),
      .adv       (adv),
      .list_mode (list_mode),
      .ofs       (ofs),
      .field_addr(mem_addr)
   );

endmodule

// File: rtl/dsc_fetch_chk.sv
module dsc_fetch_chk #(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          mem_ack,
   input logic          desc_valid,
   input logic [AW-1:0] desc_addr,
   input logic [DW-1:0] desc_len,
   input logic          xfer_done,
   input logic          irq_end,
   input logic          irq_done
);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !desc_valid));

   p_end_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_end |-> (!busy && !desc_valid));

   p_end_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_end |=> !irq_end);

   p_no_empty_desc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> (desc_len != '0));

   p_desc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && !xfer_done) |=>
         (desc_valid && $stable(desc_addr) && $stable(desc_len)));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |=> !irq_done);

   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=>
         (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

endmodule

bind dsc_fetch dsc_fetch_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .desc_valid(desc_valid),
   .desc_addr (desc_addr),
   .desc_len  (desc_len),
   .xfer_done (xfer_done),
   .irq_end   (irq_end),
   .irq_done  (irq_done)
);

// File: tb/dsc_fetch_tb.sv
module dsc_fetch_tb_top;

   localparam int AW = 32;
   localparam int DW = 16;

   typedef struct packed {
      logic        list;
      logic        ring;
      logic [15:0] head;
      logic [7:0]  ndesc;
      logic [15:0] lsum;
      logic [31:0] asum;
      logic [7:0]  nwr;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b0, 1'b0, 16'h0000, 8'd2, 16'd12, 32'h0003_3000, 8'd2},
      '{1'b0, 1'b1, 16'h0000, 8'd2, 16'd12, 32'h0003_3000, 8'd5},
      '{1'b1, 1'b0, 16'h0080, 8'd2, 16'd12, 32'h0007_7000, 8'd2},
      '{1'b1, 1'b1, 16'h0080, 8'd2, 16'd12, 32'h0007_7000, 8'd5},
      '{1'b0, 1'b0, 16'h0040, 8'd0, 16'd0,  32'h0000_0000, 8'd0},
      '{1'b1, 1'b1, 16'h00A0, 8'd0, 16'd0,  32'h0000_0000, 8'd1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, start_list = 1'b0, start_ring = 1'b0;
   logic [AW-1:0] head_ptr = '0;
   logic          busy, mem_req, mem_we, desc_valid, irq_end, irq_done;
   logic [AW-1:0] mem_addr, desc_addr;
   logic [DW-1:0] mem_wdata, mem_rdata, desc_len, xfer_status;
   logic          mem_ack = 1'b0;
   logic          done_r = 1'b0, eager = 1'b0, xfer_done;

   logic [15:0] mem [0:255];

   int total = 0, fails = 0, cyc = 0;
   int ndesc, nwr, nend, ndone, nacc, dly;
   logic [15:0] lsum;
   logic [31:0] asum;
   logic        dv_prev = 1'b0;
   logic [15:0] acc_a [0:63];
   logic        acc_w [0:63];
   logic [15:0] acc_d [0:63];

   always #2.5 clk = ~clk;

   assign mem_rdata   = mem[mem_addr[8:1]];
   assign xfer_done   = eager | done_r;
   assign xfer_status = 16'hA000 | desc_len;

   dsc_fetch #(.AW(AW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .start_list(start_list),
      .start_ring(start_ring), .head_ptr(head_ptr), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .desc_valid(desc_valid), .desc_addr(desc_addr), .desc_len(desc_len),
      .xfer_done(xfer_done), .xfer_status(xfer_status),
      .irq_end(irq_end), .irq_done(irq_done)
   );

   // memory model, descriptor monitor and transfer responder, all at negedge
   always @(negedge clk) begin
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
         if (nacc < 64) begin
            acc_a[nacc] = mem_addr[15:0];
            acc_w[nacc] = mem_we;
            acc_d[nacc] = mem_wdata;
         end
         nacc = nacc + 1;
         if (mem_we) begin
            mem[mem_addr[8:1]] = mem_wdata;
            nwr = nwr + 1;
         end
         mem_ack <= 1'b1;
      end
      if (desc_valid && !dv_prev) begin
         ndesc = ndesc + 1;
         lsum  = lsum + desc_len;
         asum  = asum + desc_addr;
      end
      dv_prev = desc_valid;
      if (done_r) begin
         done_r <= 1'b0;
         dly = 0;
      end else if (desc_valid) begin
         dly = dly + 1;
         if (dly >= 3) done_r <= 1'b1;
      end
      if (irq_end)  nend  = nend + 1;
      if (irq_done) ndone = ndone + 1;
   end

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > 150000) begin
         total = total + 1;
         fails = fails + 1;
         $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
         summary();
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total = total + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic put_tab(input int base, input logic [31:0] a, input logic [15:0] len);
      mem[base/2]     = a[15:0];
      mem[base/2 + 1] = a[31:16];
      mem[base/2 + 2] = len;
      mem[base/2 + 3] = 16'h0;
   endtask

   task automatic put_node(input int base, input logic [31:0] a, input logic [15:0] len,
                           input logic [31:0] nxt);
      put_tab(base, a, len);
      mem[base/2 + 4] = nxt[15:0];
      mem[base/2 + 5] = nxt[31:16];
   endtask

   task automatic init_mem();
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
      put_tab(16'h000, 32'h0001_1000, 16'd5);
      put_tab(16'h008, 32'h0002_2000, 16'd7);
      put_tab(16'h010, 32'h0009_9000, 16'd0);
      put_tab(16'h040, 32'h0008_8000, 16'd0);
      put_node(16'h080, 32'h0003_3000, 16'd3, 32'h0000_00C0);
      put_node(16'h0C0, 32'h0004_4000, 16'd9, 32'h0000_00A0);
      put_node(16'h0A0, 32'h0005_5000, 16'd0, 32'h0000_0080);
   endtask

   task automatic run(input logic lst, input logic rng, input logic [15:0] hd,
                      input logic eg, input logic poke);
      int t;
      init_mem();
      ndesc = 0; nwr = 0; nend = 0; ndone = 0; nacc = 0; dly = 0;
      lsum = '0; asum = '0;
      eager = eg;
      @(negedge clk);
      start = 1'b1; start_list = lst; start_ring = rng; head_ptr = {16'h0, hd};
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         t = 0;
         while (!desc_valid && t < 500) begin @(negedge clk); t++; end
         start = 1'b1; start_list = 1'b0; start_ring = 1'b0; head_ptr = 32'h40;
         @(negedge clk);
         start = 1'b0;
      end
      t = 0;
      while (nend == 0 && t < 3000) begin @(negedge clk); t++; end
      repeat (3) @(negedge clk);
      eager = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !mem_req && !desc_valid && !irq_end && !irq_done, "R1 reset quiet",
            {27'h0, busy, mem_req, desc_valid, irq_end, irq_done}, 32'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(!busy && !mem_req, "R1 idle without start", {30'h0, busy, mem_req}, 32'h0);

      // table walk
      for (int v = 0; v < 6; v++) begin
         run(VECS[v].list, VECS[v].ring, VECS[v].head, 1'b0, 1'b0);
         check(ndesc == VECS[v].ndesc, VECS[v].list ? "R3 descriptor count" : "R2 descriptor count",
               ndesc, VECS[v].ndesc);
         check(lsum == VECS[v].lsum, "R6 length sum", lsum, VECS[v].lsum);
         check(asum == VECS[v].asum, "R6 address sum", asum, VECS[v].asum);
         check(nwr == VECS[v].nwr, "R5 R7 write count", nwr, VECS[v].nwr);
         check(nend == 1, "R4 one end pulse", nend, 1);
         check(ndone == ndesc, "R7 done pulses", ndone, ndesc);
      end

      // R2 access order and status value, table layout without recycle
      run(1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);
      check(acc_a[0] == 16'h0 && acc_a[1] == 16'h2 && acc_a[2] == 16'h4, "R2 field offsets",
            {acc_a[1], acc_a[2]}, 32'h0002_0004);
      check(acc_a[3] == 16'h6 && acc_w[3], "R7 status write at +6", {15'h0, acc_w[3], acc_a[3]},
            32'h0001_0006);
      check(acc_a[4] == 16'h8, "R2 next entry base+8", acc_a[4], 32'h8);
      check(mem[3] == 16'hA005, "R7 status value", mem[3], 32'hA005);
      check(mem[2] == 16'd5, "R5 length kept without recycle", mem[2], 32'd5);
      check(nacc == 11, "R9 access count", nacc, 11);

      // R5 recycle ordering
      run(1'b0, 1'b1, 16'h0000, 1'b0, 1'b0);
      check(acc_a[3] == 16'h4 && acc_w[3] && acc_d[3] == 16'h0, "R5 zero write after length",
            {acc_d[3], acc_a[3]}, 32'h0000_0004);
      check(mem[2] == 16'h0 && mem[6] == 16'h0 && mem[10] == 16'h0, "R5 lengths cleared",
            {mem[2], mem[6]}, 32'h0);

      // R3 chained access order
      run(1'b1, 1'b0, 16'h0080, 1'b0, 1'b0);
      check(acc_a[3] == 16'h88 && acc_a[4] == 16'h8A, "R3 pointer fields",
            {acc_a[3], acc_a[4]}, 32'h0088_008A);
      check(acc_a[6] == 16'hC0, "R3 follow pointer", acc_a[6], 32'hC0);

      // issue and completion in the same cycle
      run(1'b1, 1'b1, 16'h0080, 1'b1, 1'b0);
      check(ndesc == 2 && ndone == 2, "R7 eager completion count", {ndesc[15:0], ndone[15:0]},
            32'h0002_0002);
      check(mem[16'h86/2] == 16'hA003 && mem[16'hC6/2] == 16'hA009, "R7 eager status values",
            {mem[16'h86/2], mem[16'hC6/2]}, 32'hA003_A009);

      // R8 start while busy
      run(1'b0, 1'b0, 16'h0000, 1'b0, 1'b1);
      check(ndesc == 2 && asum == 32'h0003_3000, "R8 restart ignored", ndesc, 2);

      summary();
      $finish;
   end

endmodule